// File: doc/BRIEF.md
# Registered Eight-Operation ALU

This block is the arithmetic and logic stage of a small packet-processing controller. On a clock edge where the load strobe is high, it captures two operands and a 3-bit operation code into internal registers. On the following edge it writes the outcome into a result register, along with a carry/borrow bit and three magnitude flags. The result is never produced combinationally from the input pins, so every output comes straight from a flip-flop.

There are eight operations: add, subtract, bitwise AND, OR and XOR, inversion of the first operand, negation of the first operand, and unsigned magnitude compare. Addition, subtraction and negation all use one carry-lookahead adder. For subtraction and negation a mode input inverts the adder's second input and forces its carry-in to one. While the strobe is low, the captured operands and code stay as they are. The result register keeps reloading from those held values, so the outputs stay steady.

Top module: `opsel_alu`

## Requirements
- R1: Code 3'b000 gives A+B modulo 256 on the result bus, and `carry` gives the ninth bit of the sum.
- R2: Code 3'b001 gives A−B modulo 256. `carry` is the borrow: 1 exactly when A < B as unsigned numbers.
- R3: Codes 3'b010, 3'b011 and 3'b101 give A AND B, A OR B and A XOR B, each computed bit by bit.
- R4: Code 3'b100 gives the bitwise inverse of A. The value of B has no effect on any output.
- R5: Code 3'b110 gives the two's complement of A, i.e. (~A)+1 modulo 256. So 8'h80 gives 8'h80 and 8'h00 gives 8'h00. B has no effect.
- R6: Code 3'b111 compares A and B as unsigned numbers and raises exactly one of `a_gt_b`, `a_eq_b`, `a_lt_b`. The result bus reads 8'h00.
- R7: For any code other than 3'b111 all three compare flags are 0. For any code other than 3'b000 and 3'b001, `carry` is 0.
- R8: Operands and code are captured on a rising edge with `load` high. The matching result, carry and flags appear after the next rising edge, one cycle after capture.
- R9: While `load` is low, changes on `opnd_a`, `opnd_b` and `op_code` have no effect. The outputs keep showing the last captured operation.
- R10: When `rst` is high at a rising edge, the captured operands, the captured code, the result, `carry` and all flags become 0. The reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for operands and code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| op_code | input | 3 | Operation select |
| result | output | 8 | Registered result |
| carry | output | 1 | Carry (add) or borrow (subtract), else 0 |
| a_gt_b | output | 1 | Compare flag: A greater than B |
| a_eq_b | output | 1 | Compare flag: A equal to B |
| a_lt_b | output | 1 | Compare flag: A less than B |

## Verification
The result register reloads every cycle from the held operand registers. A corrupted held operand or code therefore shows on `result`, `carry` or the flags one cycle after the corruption, and it stays visible until the next load. A capture that happens while `load` is low, or a missed capture when it is high, shows up in the first result compared after it. A lookahead carry that is wrong in one group shows only for operand pairs whose carries cross that group boundary. For that reason the vectors include carries that run across the full width and borrows that wrap around zero. A flag-gating fault breaks the one-of-three rule, or leaves a flag set on a non-compare result, in the same cycle as that result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_INV = 3'b100,
        OP_XOR = 3'b101,
        OP_NEG = 3'b110,
        OP_CMP = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } mag_flags_t;

    function automatic logic op_uses_adder(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG);
    endfunction

    function automatic logic op_inverts_b(alu_op_e op);
        return (op == OP_SUB) || (op == OP_NEG);
    endfunction

endpackage

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int W   = 8,
    parameter int GRP = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub_mode,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NG = W / GRP;

    logic [W-1:0] y_eff;
    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W-1:0] cin_bit;
    logic [NG:0]  grp_c;

    // mode input: invert second operand and inject carry for subtraction
    assign y_eff    = y ^ {W{sub_mode}};
    assign prop     = x ^ y_eff;
    assign gen      = x & y_eff;
    assign grp_c[0] = sub_mode;

    genvar k;
    generate
        for (k = 0; k < NG; k++) begin : g_grp
            localparam int BASE = k * GRP;
            logic [GRP:0] c_loc;

            // closed-form lookahead inside the group
            always_comb begin
                logic term;
                logic pchain;
                c_loc[0] = grp_c[k];
                for (int i = 1; i <= GRP; i++) begin
                    term   = 1'b0;
                    pchain = 1'b1;
                    for (int j = i - 1; j >= 0; j--) begin
                        term   = term | (pchain & gen[BASE + j]);
                        pchain = pchain & prop[BASE + j];
                    end
                    c_loc[i] = term | (pchain & grp_c[k]);
                end
            end

            assign cin_bit[BASE + GRP - 1 : BASE] = c_loc[GRP-1:0];
            assign grp_c[k+1] = c_loc[GRP];
        end
    endgenerate

    assign sum  = prop ^ cin_bit;
    assign cout = grp_c[NG];

endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_INV:  y = ~a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mag_compare.sv
module mag_compare
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output mag_flags_t   flags
);
    always_comb begin
        flags.gt = (a > b);
        flags.eq = (a == b);
        flags.lt = (a < b);
    end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
    import alu_pkg::*;
#(
    parameter int W   = 8,
    parameter int GRP = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_code,
    output logic [W-1:0] result,
    output logic         carry,
    output logic         a_gt_b,
    output logic         a_eq_b,
    output logic         a_lt_b
);
    typedef struct packed {
        logic [W-1:0] opa;
        logic [W-1:0] opb;
        alu_op_e      op;
        logic [W-1:0] res;
        logic         cy;
        mag_flags_t   flg;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic [W-1:0] add_x, add_y, add_sum;
    logic         add_cout;
    logic [W-1:0] bit_y;
    mag_flags_t   cmp_flags;

    // adder operand steering: negation is 0 + ~A + 1
    always_comb begin
        add_x = (st_q.op == OP_NEG) ? '0 : st_q.opa;
        add_y = (st_q.op == OP_NEG) ? st_q.opa : st_q.opb;
    end

    cla_adder #(.W(W), .GRP(GRP)) u_add (
        .x        (add_x),
        .y        (add_y),
        .sub_mode (op_inverts_b(st_q.op)),
        .sum      (add_sum),
        .cout     (add_cout)
    );

    bitwise_unit #(.W(W)) u_bit (
        .a  (st_q.opa),
        .b  (st_q.opb),
        .op (st_q.op),
        .y  (bit_y)
    );

    mag_compare #(.W(W)) u_cmp (
        .a     (st_q.opa),
        .b     (st_q.opb),
        .flags (cmp_flags)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.opa = opnd_a;
            st_d.opb = opnd_b;
            st_d.op  = alu_op_e'(op_code);
        end
        st_d.flg = '0;
        st_d.cy  = 1'b0;
        if (op_uses_adder(st_q.op)) begin
            st_d.res = add_sum;
        end else if (st_q.op == OP_CMP) begin
            st_d.res = '0;
            st_d.flg = cmp_flags;
        end else begin
            st_d.res = bit_y;
        end
        if (st_q.op == OP_ADD) st_d.cy = add_cout;
        if (st_q.op == OP_SUB) st_d.cy = ~add_cout;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result = st_q.res;
    assign carry  = st_q.cy;
    assign a_gt_b = st_q.flg.gt;
    assign a_eq_b = st_q.flg.eq;
    assign a_lt_b = st_q.flg.lt;

    AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (st_q.op == OP_CMP) |=> ($countones({a_gt_b, a_eq_b, a_lt_b}) == 1 && result == '0)); // R6
    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q.op != OP_CMP) |=> ({a_gt_b, a_eq_b, a_lt_b} == 3'b000)); // R7
    AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q.op != OP_ADD && st_q.op != OP_SUB) |=> !carry); // R7
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(st_q.opa) && $stable(st_q.opb) && $stable(st_q.op))); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result == '0 && !carry && !a_gt_b && !a_eq_b && !a_lt_b)); // R10
    AST_NEG_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (st_q.op == OP_NEG) |=> !carry); // R5

endmodule

// File: tb/opsel_alu_tb.sv
`timescale 1ns/1ps
module opsel_alu_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic [2:0] op_code = '0;
    logic [7:0] result;
    logic       carry, a_gt_b, a_eq_b, a_lt_b;

    opsel_alu u_dut (
        .clk(clk), .rst(rst), .load(load),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code),
        .result(result), .carry(carry),
        .a_gt_b(a_gt_b), .a_eq_b(a_eq_b), .a_lt_b(a_lt_b)
    );

    always #5 clk = ~clk;

    typedef struct {
        int         due;
        logic [7:0] r;
        logic       c, g, e, l;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t last_exp;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t model(logic [7:0] a, logic [7:0] b, logic [2:0] s, string tag);
        exp_t x;
        logic [8:0] wide;
        x.r = 8'h00; x.c = 0; x.g = 0; x.e = 0; x.l = 0; x.tag = tag; x.due = 0;
        case (s)
            3'd0: begin wide = {1'b0, a} + {1'b0, b}; x.r = wide[7:0]; x.c = wide[8]; end
            3'd1: begin x.r = a - b; x.c = (a < b); end
            3'd2: x.r = a & b;
            3'd3: x.r = a | b;
            3'd4: x.r = ~a;
            3'd5: x.r = a ^ b;
            3'd6: x.r = 8'h00 - a;
            default: begin x.g = (a > b); x.e = (a == b); x.l = (a < b); end
        endcase
        return x;
    endfunction

    task automatic compare(exp_t x);
        total++;
        if (result !== x.r || carry !== x.c || a_gt_b !== x.g || a_eq_b !== x.e || a_lt_b !== x.l) begin
            bad++;
            $display("FAIL %s: got res=%h c=%b f=%b%b%b exp res=%h c=%b f=%b%b%b", x.tag,
                     result, carry, a_gt_b, a_eq_b, a_lt_b, x.r, x.c, x.g, x.e, x.l);
        end
    endtask

    // monitor: pops expected items when their result cycle is reached
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t x;
            x = q.pop_front();
            if (x.due < cyc) begin
                total++; bad++;
                $display("FAIL %s: check missed at cycle %0d exp cycle %0d", x.tag, cyc, x.due);
            end else begin
                compare(x);
            end
        end
    end

    // driver: one operation per cycle, result expected two edges later (R8)
    task automatic issue(logic [7:0] a, logic [7:0] b, logic [2:0] s, string tag);
        exp_t x;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_code = s; load = 1'b1;
        x = model(a, b, s, tag);
        x.due = cyc + 2;
        last_exp = x;
        q.push_back(x);
    endtask

    // strobe low, inputs scrambled: outputs must hold (R9)
    task automatic hold_scrambled(int n);
        for (int i = 0; i < n; i++) begin
            exp_t x;
            @(negedge clk);
            load = 1'b0;
            opnd_a = 8'h5A ^ 8'(i * 37); opnd_b = 8'hC3 + 8'(i); op_code = 3'(i + 3);
            x = last_exp;
            x.due = cyc + 2;
            x.tag = "R9";
            q.push_back(x);
        end
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_t z;
        z = model(8'h00, 8'h00, 3'd0, "R10");
        repeat (3) @(negedge clk);
        compare(z);                                   // R10 reset state
        rst = 1'b0;

        // R1 add with carry across groups
        issue(8'h7F, 8'h01, 3'd0, "R1");
        issue(8'hFF, 8'h01, 3'd0, "R1");
        issue(8'hC8, 8'h64, 3'd0, "R1");
        issue(8'h0F, 8'h01, 3'd0, "R1");
        // R2 subtract with borrow
        issue(8'h05, 8'h03, 3'd1, "R2");
        issue(8'h03, 8'h05, 3'd1, "R2");
        issue(8'h10, 8'h10, 3'd1, "R2");
        issue(8'h00, 8'hFF, 3'd1, "R2");
        // R3 bitwise
        issue(8'hAA, 8'h0F, 3'd2, "R3");
        issue(8'hAA, 8'h0F, 3'd3, "R3");
        issue(8'hAA, 8'h0F, 3'd5, "R3");
        // R4 invert A, B irrelevant
        issue(8'h3C, 8'hFF, 3'd4, "R4");
        issue(8'h3C, 8'h00, 3'd4, "R4");
        // R5 negate
        issue(8'h80, 8'h11, 3'd6, "R5");
        issue(8'h00, 8'hFF, 3'd6, "R5");
        issue(8'h01, 8'h00, 3'd6, "R5");
        // R6 compare, unsigned
        issue(8'h80, 8'h7F, 3'd7, "R6");
        issue(8'h12, 8'h12, 3'd7, "R6");
        issue(8'h00, 8'hFF, 3'd7, "R6");
        // R7 flags and carry cleared after compare / after add
        issue(8'hFF, 8'hFF, 3'd0, "R7");
        issue(8'hFF, 8'h01, 3'd3, "R7");
        // R9 hold while strobe low
        hold_scrambled(4);
        drain();

        // R8 back-to-back sweep over all codes
        for (int i = 0; i < 64; i++)
            issue(8'(i * 29 + 7), 8'(i * 113 + 200), 3'(i), "R8");
        hold_scrambled(2);
        drain();

        // R10 mid-run synchronous reset
        issue(8'hF0, 8'h20, 3'd0, "R1");
        drain();
        @(negedge clk);
        rst = 1'b1; load = 1'b0;
        @(negedge clk);
        compare(z);                                   // R10
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        compare(z);                                   // R10 cleared operands give 0+0

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule